// File: doc/BRIEF.md
# Shared-Engine 8x8 Two-Dimensional DCT

This block takes 8x8 blocks of 8-bit pixels, one pixel per clock in row-major order, and produces the 64 fixed-point coefficients of their orthonormal two-dimensional discrete cosine transform. The transform is computed separably. A serial-to-parallel stage gathers each row of eight samples into a vector. One 1-D 8-point DCT engine transforms that row. The row results go into a transpose memory, and the same engine later transforms each column of that memory.

The engine is purely combinational and is shared in time. A ready row vector always wins the engine. A column pass runs in any other cycle, provided that a full transpose bank is waiting and the output shifter is about to empty. The transpose memory has two banks, so one block is written while the previous block is read. The input handshake holds the source off only when the bank it would fill still holds unread data.

Inside the engine, three stages use adders and subtractors only. Stage one pairs input i with input 7-i. All constant multiplications sit in the fourth stage. Each constant is cos(k·pi/16)/2 in 12-bit signed form, scaled by 2^11.

Top module: `dct2d_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, in_ready is 1 and out_valid is 0.
- R2: A pixel is taken only on a rising edge where in_valid and in_ready are both 1. Idle cycles on the input, in any pattern, do not change the coefficients produced.
- R3: Each pixel is level-shifted by subtracting 128. A block of constant value p gives a first coefficient of 8·(p-128), and all 63 others are 0, each within ±2.
- R4: Each coefficient equals the orthonormal 2-D DCT X(u,v) = ¼·C(u)·C(v)·ΣΣ (p−128)·cos((2c+1)uπ/16)·cos((2r+1)vπ/16), with C(0)=1/√2 and C(k>0)=1. It is within ±2 of the exact value rounded to the nearest integer and is output as 12-bit two's complement, so its magnitude never exceeds 1026.
- R5: The coefficients leave in column-major order. The t-th output of a block (t = 0..63) is X(u = t/8, v = t%8), where u is the horizontal frequency and v the vertical one. They leave in bursts of 8 on consecutive cycles, and the first output of a burst follows the column pass by one cycle.
- R6: Blocks are emitted in the order they arrived, with exactly 64 outputs per block.
- R7: A row result is never written into a transpose bank that holds unread data. When both banks hold unread data, in_ready is 0. Blocks streamed back to back through alternating banks come out intact.
- R8: With a sample offered on every clock, in_ready stays 1, so one pixel per clock is sustained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel is offered on in_pixel |
| in_pixel | input | 8 | Unsigned pixel, row-major within a block |
| in_ready | output | 1 | The block can take a pixel this cycle |
| out_valid | output | 1 | out_coef holds a coefficient |
| out_coef | output | 12 | Signed coefficient, column-major order |

## Verification
The bench sends flat blocks at black, mid-grey and white. A design that gets the level shift or the DC scale wrong would show the error in the first coefficient, while a leak into the AC terms would show in the 63 that should be zero. A checkerboard and an impulse drive the highest frequencies and all four odd constants. A misplaced sign, a wrong crossover pair or a swapped constant in the multiply stage would move specific coefficients far outside ±2. The first blocks are streamed with no gap, so banks alternate at full rate, and a slip in the transpose addressing or the bank toggle would scramble the column-major order. The later blocks carry random idle cycles, which would expose a deserializer that counts cycles instead of accepted samples.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NPT    = 8;   // points of the 1-D transform
  localparam int PIX_W  = 8;   // unsigned pixel width
  localparam int DAT_W  = 14;  // engine word width (signed)
  localparam int FRAC_W = 2;   // fraction bits carried between passes
  localparam int KSH    = 11;  // constants are scaled by 2^KSH
  localparam int RES_W  = 12;  // coefficient width at the output

  typedef logic signed [31:0] acc_t;

  // cos(k*pi/16)/2 scaled by 2^11, fits a 12-bit signed word
  function automatic int cos_half(input int k);
    case (k)
      1: return 1004;
      2: return 946;
      3: return 851;
      4: return 724;
      5: return 569;
      6: return 392;
      7: return 200;
      default: return 0;
    endcase
  endfunction

  function automatic acc_t kmul(input int k, input acc_t v);
    return acc_t'(cos_half(k)) * v;
  endfunction

  // arithmetic right shift with round-half-up
  function automatic acc_t shr_rnd(input acc_t v, input int sh);
    return (v + (acc_t'(1) <<< (sh - 1))) >>> sh;
  endfunction
endpackage

// File: rtl/dct_deser.sv
module dct_deser import dct_pkg::*; #(
  parameter int PW   = PIX_W,
  parameter int DW   = DAT_W,
  parameter int FRAC = FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [PW-1:0]        pix,
  output logic signed [DW-1:0] vec [NPT],
  output logic                 vec_ok
);
  localparam int SW = $clog2(NPT);
  localparam logic [SW-1:0] LAST = SW'(NPT - 1);

  logic [SW-1:0]        slot;
  logic signed [DW-1:0] lvl;

  // remove the mid-scale offset and move to the inter-pass fixed point
  assign lvl = (DW'({1'b0, pix}) - DW'(1 << (PW - 1))) <<< FRAC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      vec_ok <= 1'b0;
    end else begin
      vec_ok <= take && (slot == LAST);
      if (take) slot <= (slot == LAST) ? '0 : slot + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (take) vec[slot] <= lvl;
  end
endmodule

// File: rtl/dct_engine1d.sv
module dct_engine1d import dct_pkg::*; #(
  parameter int DW = DAT_W,
  parameter int SH = KSH
) (
  input  logic signed [DW-1:0] x [NPT],
  output logic signed [DW-1:0] y [NPT]
);
  localparam int H  = NPT / 2;
  localparam int W1 = DW + 1;
  localparam int W2 = DW + 2;
  localparam int W3 = DW + 3;

  // stage 1: crossover pairs i / NPT-1-i
  logic signed [W1-1:0] sm [H];
  logic signed [W1-1:0] df [H];
  for (genvar i = 0; i < H; i++) begin : g_st1
    assign sm[i] = W1'(x[i]) + W1'(x[NPT-1-i]);
    assign df[i] = W1'(x[i]) - W1'(x[NPT-1-i]);
  end

  // stage 2: butterflies on the even half
  logic signed [W2-1:0] es0, es1, ed0, ed1;
  assign es0 = W2'(sm[0]) + W2'(sm[3]);
  assign es1 = W2'(sm[1]) + W2'(sm[2]);
  assign ed0 = W2'(sm[0]) - W2'(sm[3]);
  assign ed1 = W2'(sm[1]) - W2'(sm[2]);

  // stage 3: final butterfly on the DC / Nyquist pair
  logic signed [W3-1:0] f_dc, f_ny;
  assign f_dc = W3'(es0) + W3'(es1);
  assign f_ny = W3'(es0) - W3'(es1);

  // stage 4: every constant multiplication lives here
  acc_t p [NPT];
  acc_t o0, o1, o2, o3;
  always_comb begin
    o0 = acc_t'(df[0]);
    o1 = acc_t'(df[1]);
    o2 = acc_t'(df[2]);
    o3 = acc_t'(df[3]);
    p[0] = kmul(4, acc_t'(f_dc));
    p[4] = kmul(4, acc_t'(f_ny));
    p[2] = kmul(2, acc_t'(ed0)) + kmul(6, acc_t'(ed1));
    p[6] = kmul(6, acc_t'(ed0)) - kmul(2, acc_t'(ed1));
    p[1] = kmul(1, o0) + kmul(3, o1) + kmul(5, o2) + kmul(7, o3);
    p[3] = kmul(3, o0) - kmul(7, o1) - kmul(1, o2) - kmul(5, o3);
    p[5] = kmul(5, o0) - kmul(1, o1) + kmul(7, o2) + kmul(3, o3);
    p[7] = kmul(7, o0) - kmul(5, o1) + kmul(3, o2) - kmul(1, o3);
  end

  for (genvar k = 0; k < NPT; k++) begin : g_out
    assign y[k] = DW'(shr_rnd(p[k], SH));
  end
endmodule

// File: rtl/dct_tbuf.sv
module dct_tbuf import dct_pkg::*; #(
  parameter int DW = DAT_W
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic                       wr_bank,
  input  logic [$clog2(NPT)-1:0]     wr_row,
  input  logic signed [DW-1:0]       wr_vec [NPT],
  input  logic                       rd_bank,
  input  logic [$clog2(NPT)-1:0]     rd_col,
  output logic signed [DW-1:0]       rd_vec [NPT]
);
  // two banks, each NPT rows by NPT columns
  logic signed [DW-1:0] mem [2][NPT][NPT];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int c = 0; c < NPT; c++) mem[wr_bank][wr_row][c] <= wr_vec[c];
    end
  end

  always_comb begin
    for (int r = 0; r < NPT; r++) rd_vec[r] = mem[rd_bank][r][rd_col];
  end
endmodule

// File: rtl/dct2d_core.sv
module dct2d_core import dct_pkg::*; #(
  parameter int PW    = PIX_W,
  parameter int DW    = DAT_W,
  parameter int FRAC  = FRAC_W,
  parameter int SH    = KSH,
  parameter int OUT_W = RES_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PW-1:0]           in_pixel,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_coef
);
  localparam int IW = $clog2(NPT);
  localparam int LW = $clog2(NPT + 1);
  localparam logic [IW-1:0] LAST = IW'(NPT - 1);

  // named events for the checker
  logic       take, row_fire, col_fire;
  logic       wbank, rbank;
  logic [1:0] bank_full;
  logic [IW-1:0] wrow, rcol;
  logic [LW-1:0] oleft;

  logic signed [DW-1:0]    row_vec [NPT];
  logic signed [DW-1:0]    col_vec [NPT];
  logic signed [DW-1:0]    eng_in  [NPT];
  logic signed [DW-1:0]    eng_out [NPT];
  logic signed [OUT_W-1:0] obuf    [NPT];

  assign in_ready = !bank_full[wbank];
  assign take     = in_valid && in_ready;
  assign col_fire = bank_full[rbank] && !row_fire && (oleft <= LW'(1));

  dct_deser #(.PW(PW), .DW(DW), .FRAC(FRAC)) u_deser (
    .clk(clk), .rst_n(rst_n), .take(take), .pix(in_pixel),
    .vec(row_vec), .vec_ok(row_fire)
  );

  // one engine, row pass has priority
  always_comb begin
    for (int k = 0; k < NPT; k++) eng_in[k] = row_fire ? row_vec[k] : col_vec[k];
  end

  dct_engine1d #(.DW(DW), .SH(SH)) u_eng (.x(eng_in), .y(eng_out));

  dct_tbuf #(.DW(DW)) u_tbuf (
    .clk(clk), .wr_en(row_fire), .wr_bank(wbank), .wr_row(wrow), .wr_vec(eng_out),
    .rd_bank(rbank), .rd_col(rcol), .rd_vec(col_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank <= 1'b0;
      wrow  <= '0;
      rbank <= 1'b0;
      rcol  <= '0;
    end else begin
      if (row_fire) begin
        wrow <= (wrow == LAST) ? '0 : wrow + IW'(1);
        if (wrow == LAST) wbank <= ~wbank;
      end
      if (col_fire) begin
        rcol <= (rcol == LAST) ? '0 : rcol + IW'(1);
        if (rcol == LAST) rbank <= ~rbank;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_full[b] <= 1'b0;
      else if (row_fire && (wbank == 1'(b)) && (wrow == LAST)) bank_full[b] <= 1'b1;
      else if (col_fire && (rbank == 1'(b)) && (rcol == LAST)) bank_full[b] <= 1'b0;
    end
  end

  // output shifter: one column of coefficients per burst
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oleft <= '0;
    else if (col_fire) oleft <= LW'(NPT);
    else if (oleft != '0) oleft <= oleft - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (col_fire) begin
      for (int k = 0; k < NPT; k++) obuf[k] <= OUT_W'(shr_rnd(acc_t'(eng_out[k]), FRAC));
    end else if (oleft != '0) begin
      for (int k = 0; k < NPT - 1; k++) obuf[k] <= obuf[k+1];
    end
  end

  assign out_valid = (oleft != '0);
  assign out_coef  = obuf[0];
endmodule

// File: rtl/dct2d_chk.sv
module dct2d_chk #(
  parameter int PW    = 8,
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_coef,
  input logic             row_fire,
  input logic             col_fire,
  input logic             wbank,
  input logic [1:0]       bank_full
);
  localparam int LIM = (1 << (PW + 2)) + 2;

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_fire |-> !bank_full[wbank]);

  // R7
  dual_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_full[0] && bank_full[1]) |-> !in_ready);

  // R5
  col_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_fire |=> out_valid);

  // R5
  col_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_fire |=> !col_fire);

  // R4
  coef_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_coef) <= LIM && $signed(out_coef) >= -LIM));
endmodule

bind dct2d_core dct2d_chk #(.PW(PW), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_coef(out_coef), .row_fire(row_fire), .col_fire(col_fire),
  .wbank(wbank), .bank_full(bank_full)
);

// File: tb/sim_dct2d_core.sv
module sim_dct2d_core;
  localparam int  NB = 14;
  localparam real PI = 3.14159265358979;

  logic       clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_pixel = 0;
  wire        in_ready, out_valid;
  wire [11:0] out_coef;

  always #10 clk = ~clk;

  dct2d_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
    .in_ready(in_ready), .out_valid(out_valid), .out_coef(out_coef)
  );

  int pix [NB][64];
  int got [NB][64];
  int n_checks = 0, n_fail = 0, n_out = 0, run = 0, stalls = 0;
  bit finished = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real ref_coef(input int b, input int u, input int v);
    real acc = 0.0, cu, cv;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        acc += real'(pix[b][r*8+c] - 128) * $cos(real'((2*c+1)*u) * PI / 16.0)
                                          * $cos(real'((2*r+1)*v) * PI / 16.0);
    cu = (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
    cv = (v == 0) ? 1.0 / $sqrt(2.0) : 1.0;
    return 0.25 * cu * cv * acc;
  endfunction

  task automatic check_block(input int b);
    int bad = 0;
    string tag;
    tag = (b < 3) ? "R3" : (b < 7) ? "R4" : "R2";
    for (int t = 0; t < 64; t++) begin
      int e, a;
      e = int'(ref_coef(b, t / 8, t % 8));   // R5 column-major index
      a = got[b][t];
      if (a - e > 2 || e - a > 2) bad++;
      chk(a - e <= 2 && e - a <= 2, tag, $sformatf("blk %0d coef u=%0d v=%0d", b, t/8, t%8), a, e);
    end
    if (b < 7) chk(bad == 0, "R7", $sformatf("blk %0d intact through banks", b), bad, 0);
  endtask

  function automatic logic [15:0] lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (n_out < NB * 64) got[n_out / 64][n_out % 64] = $signed(out_coef);
        n_out++;
        run++;
        if (n_out % 64 == 0 && n_out <= NB * 64) check_block(n_out / 64 - 1);
      end else if (run > 0) begin
        chk(run % 8 == 0, "R5", "burst length multiple of 8", run, 8 * ((run + 7) / 8));
        run = 0;
      end
    end
  end

  task automatic send_block(input int b, input bit gaps);
    int p = 0;
    while (p < 64) begin
      @(negedge clk);
      lf = lfsr(lf);
      if (gaps && lf[1:0] == 2'b00) begin
        in_valid = 0;
        in_pixel = 8'hFF;
      end else begin
        in_valid = 1;
        in_pixel = 8'(pix[b][p]);
        if (in_ready) p++;
        else stalls++;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      int r = i / 8, c = i % 8;
      pix[0][i] = 128;
      pix[1][i] = 0;
      pix[2][i] = 255;
      pix[3][i] = ((r + c) % 2 == 1) ? 255 : 0;
      pix[4][i] = c * 32 + 16;
      pix[5][i] = r * 36;
      pix[6][i] = (i == 27) ? 255 : 128;
    end
    for (int b = 7; b < NB; b++)
      for (int i = 0; i < 64; i++) begin
        lf = lfsr(lf);
        pix[b][i] = int'(lf[7:0]);
      end

    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    for (int b = 0; b < 7; b++) send_block(b, 1'b0);
    chk(stalls == 0, "R8", "stall cycles at full rate", stalls, 0);
    for (int b = 7; b < NB; b++) send_block(b, 1'b1);
    @(negedge clk);
    in_valid = 0;

    wait (n_out >= NB * 64);
    repeat (40) @(negedge clk);
    chk(n_out == NB * 64, "R6", "total coefficients", n_out, NB * 64);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d outputs expected %0d", n_out, NB * 64);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule